// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block takes eight interrupt request lines and keeps a pending bit and an in-service bit for each line. A per-line trigger-mode vector sets whether a line is sampled by its level or latched on a rising edge. Among the unmasked pending lines it picks the winner by scanning from a rotatable base level. It raises a registered interrupt output only when that winner outranks every line already in service. The 3-bit level of the winner is reported beside the interrupt output.

A command decoder outside this block supplies the mask, the trigger modes, the mode flags and the base-level loads. The same decoder clears in-service bits when software ends an interrupt. The processor side pulses an acknowledge strobe to accept the reported level. On acknowledge the block marks that level in service, or with automatic end-of-interrupt leaves it out of service, and can then rotate the base past it. When the block acts as the master of a cascade and special nesting is selected, the in-service bit of the cascade line is left out of the nesting comparison. A slave behind the cascade line can then present a further request.

Top module: `rot_prio_resolver`

## Requirements
- R1: In a cycle with `rst` high, every pending, in-service and last-sample bit clears, the base level becomes 0, and `irq_out` and `level_out` read 0 on the following cycle.
- R2: For a line whose `trig_level` bit is 0 (edge mode), the pending bit is set when the line reads 1 after reading 0 on the previous cycle. It stays set after the line falls, until the line is acknowledged.
- R3: For a line whose `trig_level` bit is 1 (level mode), the pending bit equals the line value sampled on the previous clock edge.
- R4: A line whose `mask_in` bit is 1 keeps its pending bit but never wins resolution. Once the mask bit returns to 0, the held request is served.
- R5: The winner is the pending unmasked line with the smallest offset, where offset = (line - base) mod 8. `level_out` reports its line number. A `base_wr` pulse loads `base_val` into the base level at the next edge.
- R6: `irq_out` rises only if the winning offset is strictly smaller than the smallest offset among in-service lines. An equal or lower pending line raises nothing.
- R7: With `nest_special` and `is_master` both 1, in-service line 2 is left out of the nesting comparison. A new request on line 2 then raises `irq_out` although line 2 is in service.
- R8: An `ack_in` pulse while `irq_out` is 1 sets the in-service bit of `level_out` and clears that line's pending bit if it is in edge mode, leaving a level-mode pending bit as it is. It forces `irq_out` to 0 on the next cycle.
- R9: With `auto_eoi` set, an accepted acknowledge leaves no in-service bit set. With `rot_on_aeoi` also set, the base level becomes (`level_out` + 1) mod 8 unless `base_wr` is pulsed in the same cycle, in which case `base_wr` wins.
- R10: An `ack_in` pulse while `irq_out` is 0 changes no pending bit, in-service bit or base level.
- R11: A rising edge on a line in the same cycle as the acceptance of that same line leaves its pending bit set.
- R12: Each 1 bit of `isr_clr` clears the matching in-service bit at the next edge. An acknowledge in the same cycle sets its bit regardless.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line trigger mode: 1 level, 0 rising edge |
| mask_in | input | 8 | Per-line mask: 1 excludes the line from resolution |
| isr_clr | input | 8 | Per-line in-service clear strobes |
| base_wr | input | 1 | Load strobe for the base level |
| base_val | input | 3 | Base level to load |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_on_aeoi | input | 1 | Rotate the base past the acknowledged level under automatic end-of-interrupt |
| nest_special | input | 1 | Special nesting: ignore the cascade line's in-service bit |
| is_master | input | 1 | Block acts as cascade master |
| ack_in | input | 1 | Interrupt acknowledge strobe |
| irq_out | output | 1 | Registered interrupt request |
| level_out | output | 3 | Level of the pending winner |

## Verification
Two functions can land on the same clock edge for the same line: clearing the edge-mode pending bit on acknowledge, and setting it again on a fresh rising edge. The bench lets a latched line fall, then raises it again in the very cycle the acknowledge pulse is driven. It then clears the in-service bit and expects the interrupt to come back at that level, which shows that the new edge won. A second case acknowledges a line whose input stays high and applies the same in-service clear. There the interrupt must stay low, which shows that the clear itself works when no new edge arrives.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    // Number of request lines; must be a power of two so level sums wrap by truncation.
    localparam int unsigned LINES        = 8;
    localparam int unsigned LVL_W        = $clog2(LINES);
    // Line that carries a slave's request when acting as cascade master.
    localparam int unsigned CASCADE_LINE = 2;

    typedef logic [LINES-1:0] vec_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        vec_t irr;   // pending requests
        vec_t last;  // line values sampled on the previous edge
        vec_t isr;   // lines in service
        lvl_t base;  // rotation base level
        logic irq;   // registered interrupt output
        lvl_t lvl;   // registered winning level
    } state_t;
endpackage

// File: rtl/rpr_scan.sv
module rpr_scan #(
    parameter int unsigned N = rpr_pkg::LINES,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] base,
    output logic [W:0]   off     // N when vec is empty
);
    logic [W-1:0] idx;

    // Walk offsets downward so the smallest offset that hits is the last write.
    always_comb begin
        off = (W+1)'(N);
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = base + W'(k);
            if (vec[idx]) begin
                off = (W+1)'(k);
            end
        end
    end
endmodule

// File: rtl/rpr_capture.sv
module rpr_capture #(
    parameter int unsigned N = rpr_pkg::LINES
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] level_mode,
    input  logic [N-1:0] last,
    input  logic [N-1:0] irr,
    input  logic [N-1:0] clr,
    output logic [N-1:0] irr_nxt
);
    logic [N-1:0] rise;

    always_comb begin
        rise = req & ~last;
        // Level lines mirror the input; edge lines hold until cleared, a new rise beats the clear.
        irr_nxt = (level_mode & req) | (~level_mode & ((irr & ~clr) | rise));
    end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
    import rpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] req_in,
    input  logic [LINES-1:0] trig_level,
    input  logic [LINES-1:0] mask_in,
    input  logic [LINES-1:0] isr_clr,
    input  logic             base_wr,
    input  logic [LVL_W-1:0] base_val,
    input  logic             auto_eoi,
    input  logic             rot_on_aeoi,
    input  logic             nest_special,
    input  logic             is_master,
    input  logic             ack_in,
    output logic             irq_out,
    output logic [LVL_W-1:0] level_out
);
    state_t st_q, st_d;

    vec_t         pend_vec;
    vec_t         svc_vec;
    vec_t         ack_vec;
    vec_t         irr_nxt;
    logic [LVL_W:0] pend_off;
    logic [LVL_W:0] svc_off;
    lvl_t         win_lvl;
    logic         take;

    // Candidate and in-service vectors feeding the two scanners.
    always_comb begin
        pend_vec = st_q.irr & ~mask_in;
        svc_vec  = st_q.isr;
        if (nest_special && is_master) begin
            svc_vec[CASCADE_LINE] = 1'b0;
        end
        take    = ack_in && st_q.irq;
        ack_vec = take ? (vec_t'(1) << st_q.lvl) : '0;
    end

    rpr_scan #(.N(LINES)) u_scan_pend (
        .vec  (pend_vec),
        .base (st_q.base),
        .off  (pend_off)
    );

    rpr_scan #(.N(LINES)) u_scan_svc (
        .vec  (svc_vec),
        .base (st_q.base),
        .off  (svc_off)
    );

    rpr_capture #(.N(LINES)) u_capture (
        .req        (req_in),
        .level_mode (trig_level),
        .last       (st_q.last),
        .irr        (st_q.irr),
        .clr        (ack_vec),
        .irr_nxt    (irr_nxt)
    );

    always_comb begin
        win_lvl = st_q.base + pend_off[LVL_W-1:0];
        st_d    = st_q;

        st_d.last = req_in;
        st_d.irr  = irr_nxt;

        st_d.isr = st_q.isr & ~isr_clr;
        if (take && !auto_eoi) begin
            st_d.isr = st_d.isr | ack_vec;
        end

        if (base_wr) begin
            st_d.base = base_val;
        end else if (take && auto_eoi && rot_on_aeoi) begin
            st_d.base = st_q.lvl + lvl_t'(1);
        end

        // Strict nesting; output held low for the cycle after an accepted acknowledge.
        st_d.irq = (pend_off < svc_off) && !take;
        st_d.lvl = st_d.irq ? win_lvl : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_out   = st_q.irq;
    assign level_out = st_q.lvl;
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker
    import rpr_pkg::*;
(
    input logic clk,
    input logic rst,
    input vec_t req_in,
    input vec_t trig_level,
    input vec_t mask_in,
    input vec_t isr_clr,
    input logic base_wr,
    input logic auto_eoi,
    input logic rot_on_aeoi,
    input logic ack_in,
    input logic irq_out,
    input lvl_t level_out,
    input vec_t irr,
    input vec_t isr,
    input lvl_t base
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq_out && irr == '0 && isr == '0 && base == '0));

    assert_level_mirror_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((irr ^ $past(req_in)) & $past(trig_level)) == '0));

    assert_mask_honored_R4: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((($past(mask_in) >> level_out) & vec_t'(1)) == '0));

    assert_ack_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_in && irq_out) |=> !irq_out);

    assert_aeoi_no_service_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_in && irq_out && auto_eoi) |=> ((isr & ~$past(isr)) == '0));

    assert_aeoi_rotate_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_in && irq_out && auto_eoi && rot_on_aeoi && !base_wr)
        |=> (base == lvl_t'($past(level_out) + lvl_t'(1))));

    assert_stray_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (ack_in && !irq_out && isr_clr == '0) |=> (isr == $past(isr)));

    assert_service_clear_R12: assert property (@(posedge clk) disable iff (rst)
        (!ack_in && isr_clr != '0) |=> ((isr & $past(isr_clr)) == '0));
endmodule

bind rot_prio_resolver rpr_checker u_rpr_checker (
    .clk         (clk),
    .rst         (rst),
    .req_in      (req_in),
    .trig_level  (trig_level),
    .mask_in     (mask_in),
    .isr_clr     (isr_clr),
    .base_wr     (base_wr),
    .auto_eoi    (auto_eoi),
    .rot_on_aeoi (rot_on_aeoi),
    .ack_in      (ack_in),
    .irq_out     (irq_out),
    .level_out   (level_out),
    .irr         (st_q.irr),
    .isr         (st_q.isr),
    .base        (st_q.base)
);

// File: tb/test_rot_prio_resolver.sv
module test_rot_prio_resolver;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_in = '0, trig_level = '0, mask_in = '0, isr_clr = '0;
    logic       base_wr = 1'b0;
    logic [2:0] base_val = '0;
    logic       auto_eoi = 1'b0, rot_on_aeoi = 1'b0, nest_special = 1'b0, is_master = 1'b0;
    logic       ack_in = 1'b0;
    logic       irq_out;
    logic [2:0] level_out;

    int n_run = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rot_prio_resolver i_rot_prio_resolver (
        .clk(clk), .rst(rst), .req_in(req_in), .trig_level(trig_level),
        .mask_in(mask_in), .isr_clr(isr_clr), .base_wr(base_wr), .base_val(base_val),
        .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi), .nest_special(nest_special),
        .is_master(is_master), .ack_in(ack_in), .irq_out(irq_out), .level_out(level_out)
    );

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] mask;
        logic [7:0] trig;
        logic [2:0] base;
        logic       exp_irq;
        logic [2:0] exp_lvl;
    } vec_entry_t;

    // Resolution table (R5); entry 4 exercises the mask (R4), entry 8 a level line (R3).
    localparam vec_entry_t TABLE [9] = '{
        '{8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 3'd0},
        '{8'h01, 8'h00, 8'h00, 3'd0, 1'b1, 3'd0},
        '{8'h88, 8'h00, 8'h00, 3'd0, 1'b1, 3'd3},
        '{8'h88, 8'h00, 8'h00, 3'd4, 1'b1, 3'd7},
        '{8'h88, 8'h80, 8'h00, 3'd4, 1'b1, 3'd3},
        '{8'hFF, 8'hFF, 8'h00, 3'd0, 1'b0, 3'd0},
        '{8'h06, 8'h00, 8'h00, 3'd2, 1'b1, 3'd2},
        '{8'h06, 8'h00, 8'h00, 3'd3, 1'b1, 3'd1},
        '{8'h40, 8'h00, 8'h40, 3'd0, 1'b1, 3'd6}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic exp_irq, input logic [2:0] exp_lvl);
        n_run++;
        if (irq_out !== exp_irq || (exp_irq && level_out !== exp_lvl)) begin
            n_bad++;
            $display("FAIL %s: irq=%0b level=%0d, expected irq=%0b level=%0d",
                     tag, irq_out, level_out, exp_irq, exp_lvl);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_in = '0; trig_level = '0; mask_in = '0; isr_clr = '0;
        base_wr = 1'b0; base_val = '0; auto_eoi = 1'b0; rot_on_aeoi = 1'b0;
        nest_special = 1'b0; is_master = 1'b0; ack_in = 1'b0;
        step(2);
        rst = 1'b0;
    endtask

    task automatic pulse_ack();
        ack_in = 1'b1;
        step(1);
        ack_in = 1'b0;
    endtask

    task automatic pulse_clr(input logic [7:0] v);
        isr_clr = v;
        step(1);
        isr_clr = '0;
    endtask

    initial begin
        step(1);
        for (int i = 0; i < 9; i++) begin
            do_reset();
            req_in = TABLE[i].req; mask_in = TABLE[i].mask; trig_level = TABLE[i].trig;
            base_val = TABLE[i].base; base_wr = 1'b1;
            step(1);
            base_wr = 1'b0;
            step(1);
            chk($sformatf("R5 table entry %0d", i), TABLE[i].exp_irq, TABLE[i].exp_lvl);
        end

        // R1: reset state, with requests pending beforehand.
        req_in = 8'hFF;
        step(2);
        do_reset();
        chk("R1 reset state", 1'b0, 3'd0);

        // R2 edge latch persists after the line falls; R3 level line follows the input.
        req_in = 8'h20; step(1); req_in = 8'h00; step(1);
        chk("R2 edge latched", 1'b1, 3'd5);
        trig_level = 8'h10; req_in = 8'h10; step(2);
        chk("R3 level line high wins", 1'b1, 3'd4);
        req_in = 8'h00; step(2);
        chk("R3 level line dropped", 1'b1, 3'd5);

        // R6 strict nesting after acknowledging line 5 (R8).
        do_reset();
        req_in = 8'h20; step(2);
        chk("R8 before ack", 1'b1, 3'd5);
        pulse_ack();
        chk("R8 output low after ack", 1'b0, 3'd0);
        req_in = 8'hA0; step(2);
        chk("R6 lower line blocked", 1'b0, 3'd0);
        req_in = 8'hA4; step(2);
        chk("R6 higher line nests", 1'b1, 3'd2);

        // R8 edge bit cleared by ack: input held high, in-service cleared, nothing returns.
        do_reset();
        req_in = 8'h20; step(2);
        pulse_ack();
        pulse_clr(8'h20);
        step(1);
        chk("R8 edge pending cleared", 1'b0, 3'd0);

        // R8 level bit survives ack; R6 equal level blocked; R12 clear re-enables.
        do_reset();
        trig_level = 8'h08; req_in = 8'h08; step(2);
        chk("R8 level line raised", 1'b1, 3'd3);
        pulse_ack();
        step(1);
        chk("R6 equal level blocked", 1'b0, 3'd0);
        pulse_clr(8'h08);
        step(1);
        chk("R12 clear restores level request", 1'b1, 3'd3);

        // R9 automatic end-of-interrupt with rotation.
        do_reset();
        auto_eoi = 1'b1; rot_on_aeoi = 1'b1;
        req_in = 8'h09; step(2);
        chk("R9 first winner", 1'b1, 3'd0);
        pulse_ack();
        step(1);
        chk("R9 no service after auto end", 1'b1, 3'd3);
        pulse_ack();
        step(1);
        chk("R9 all served", 1'b0, 3'd0);
        req_in = 8'h08; step(1);
        req_in = 8'h29; step(2);
        chk("R9 base rotated past level 3", 1'b1, 3'd5);

        // R7 special nesting on the cascade line.
        do_reset();
        is_master = 1'b1;
        req_in = 8'h04; step(2);
        chk("R7 cascade line raised", 1'b1, 3'd2);
        pulse_ack();
        req_in = 8'h00; step(1);
        req_in = 8'h04; step(2);
        chk("R7 plain nesting blocks", 1'b0, 3'd0);
        nest_special = 1'b1; step(2);
        chk("R7 special nesting passes", 1'b1, 3'd2);

        // R11 new rise in the acknowledge cycle keeps the pending bit.
        do_reset();
        req_in = 8'h20; step(1); req_in = 8'h00; step(2);
        chk("R11 latched before ack", 1'b1, 3'd5);
        req_in = 8'h20;
        pulse_ack();
        pulse_clr(8'h20);
        step(1);
        chk("R11 pending kept through ack", 1'b1, 3'd5);

        // R4 masked line held; R10 stray ack ignored.
        do_reset();
        mask_in = 8'h01; req_in = 8'h01; step(2);
        chk("R4 masked line silent", 1'b0, 3'd0);
        pulse_ack();
        mask_in = 8'h00; step(2);
        chk("R10 stray ack ignored, R4 held request served", 1'b1, 3'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule